// File: doc/BRIEF.md
# Status Flag Register with Single-Bit Transfer Unit

This block holds the eight condition flags of a small processor core and carries out the instructions that touch single bits. It can force any flag to one or zero, either by an index or through a fixed-flag shorthand code. It can move one bit of a data byte into the transfer flag, and it can move the transfer flag back into one bit of a data byte. It can also set or clear one bit of a peripheral register value.

The execute stage pulses `start` together with an operation code, a bit index and a data byte. The flag byte is always visible on `status`. When an operation produces a modified data byte, that byte appears on `dout` and `dout_we` pulses for one cycle so the owner of the register file or peripheral bus can write it back.

Other execution units can load the whole flag byte in parallel through `flag_ld` and `flag_ld_val`. Peripheral bit operations take two cycles. While one is running, `busy` is high and the block refuses new work. The register file and the peripheral bus are outside this block.

Top module: `flag_xfer_unit`

## Requirements
- R1: Synchronous reset clears `status`, `dout`, `dout_we` and `busy` to zero. The flag bits are carry=0, zero=1, negative=2, overflow=3, sign=4, half-carry=5, transfer (T)=6, interrupt-enable=7.
- R2: Operation codes 0 and 7 to 15 are no-operations. After one of them is accepted, `status` is unchanged unless a parallel load occurs, and `dout_we` stays low.
- R3: Code 1 (flag set) makes `status[bit_idx]` equal to 1 after the edge that accepts it. All other flags keep their values.
- R4: Code 2 (flag clear) makes `status[bit_idx]` equal to 0 after the accepting edge. All other flags keep their values.
- R5: Codes 16 to 31 are fixed-flag shorthands. `op[3:1]` names the flag and `op[0]`=1 sets it, while `op[0]`=0 clears it. Each one acts exactly like code 1 or code 2 with that index.
- R6: Code 3 (store to T) copies `din[bit_idx]` into `status[6]` and leaves the other flags unchanged.
- R7: Code 4 (load from T) sets `dout` to `din` with bit `bit_idx` replaced by the T flag as it was before the edge. `dout_we` is high for the cycle after the accepting edge, and no flag changes.
- R8: Code 5 (peripheral bit set) and code 6 (peripheral bit clear) raise `busy` for one cycle after the accepting edge. At the second edge, `dout` becomes `din` (as captured at start) with bit `bit_idx` set or cleared, `dout_we` pulses for one cycle and `busy` falls. No flag changes.
- R9: A `start` that arrives while `busy` is high is ignored.
- R10: When `flag_ld` is high, `status` takes the value of `flag_ld_val` at the edge. The exception is an accepted code 1, 2, 3 or 16 to 31 in the same cycle: that operation wins, and the whole load is discarded.
- R11: All flag and T-transfer operations complete at the single edge that accepts them, and `busy` stays low for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operation request strobe |
| op | input | 5 | Operation code |
| bit_idx | input | IDX_W (3) | Bit index for flag or data |
| din | input | DATA_W (8) | Data byte operand |
| flag_ld | input | 1 | Parallel flag load enable |
| flag_ld_val | input | 8 | Parallel flag load value |
| status | output | 8 | Flag byte |
| dout | output | DATA_W (8) | Modified data byte |
| dout_we | output | 1 | One-cycle write strobe for `dout` |
| busy | output | 1 | Peripheral bit operation in progress |

## Verification
Every flag index is set and then cleared, first by index and then by shorthand code. This shows whether the index decoding or the shorthand decoding picks the wrong bit. The T store and load are run with alternating data patterns and both T polarities, so a fixed or inverted transfer bit is exposed.

Peripheral operations are issued with a competing start during the busy cycle, which shows whether a refused request leaks through. A parallel load is driven both alone and together with a flag operation, which tells the priority apart. A long random run, compared every cycle against a behavioural model, mixes all of these cases.

// File: rtl/flag_xfer_pkg.sv
package flag_xfer_pkg;
   localparam int STAT_W = 8;
   localparam int C_IDX  = 0;
   localparam int Z_IDX  = 1;
   localparam int N_IDX  = 2;
   localparam int V_IDX  = 3;
   localparam int S_IDX  = 4;
   localparam int H_IDX  = 5;
   localparam int T_IDX  = 6;
   localparam int I_IDX  = 7;

   localparam logic [4:0] OP_NOP    = 5'd0;
   localparam logic [4:0] OP_FSET   = 5'd1;
   localparam logic [4:0] OP_FCLR   = 5'd2;
   localparam logic [4:0] OP_TSTORE = 5'd3;
   localparam logic [4:0] OP_TLOAD  = 5'd4;
   localparam logic [4:0] OP_IOSET  = 5'd5;
   localparam logic [4:0] OP_IOCLR  = 5'd6;
endpackage

// File: rtl/bit_patch.sv
module bit_patch #(
   parameter int W     = 8,
   parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]     data_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic             val_i,
   output logic [W-1:0]     data_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      localparam logic [IDX_W-1:0] BI = IDX_W'(i);
      assign data_o[i] = (idx_i == BI) ? val_i : data_i[i];
   end
endmodule

// File: rtl/flag_next.sv
module flag_next
   import flag_xfer_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int IDX_W  = $clog2(DATA_W)
) (
   input  logic              accept_i,
   input  logic [4:0]        op_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [DATA_W-1:0] din_i,
   input  logic              ld_i,
   input  logic [STAT_W-1:0] ld_val_i,
   input  logic [STAT_W-1:0] status_i,
   output logic [STAT_W-1:0] status_o
);
   logic       short_op;
   logic [2:0] tgt;
   logic       do_set, do_clr, do_store, flag_op;
   logic       tbit;

   assign short_op = op_i[4];
   assign tgt      = short_op ? op_i[3:1] : idx_i[2:0];
   assign do_set   = accept_i && ((op_i == OP_FSET) || (short_op && op_i[0]));
   assign do_clr   = accept_i && ((op_i == OP_FCLR) || (short_op && !op_i[0]));
   assign do_store = accept_i && (op_i == OP_TSTORE);
   assign flag_op  = do_set || do_clr || do_store;
   assign tbit     = din_i[idx_i];

   for (genvar i = 0; i < STAT_W; i++) begin : g_flag
      localparam logic [2:0] BI = 3'(i);
      if (i == T_IDX) begin : g_t
         assign status_o[i] = (do_set && tgt == BI) ? 1'b1 :
                              (do_clr && tgt == BI) ? 1'b0 :
                              do_store              ? tbit :
                              flag_op               ? status_i[i] :
                              ld_i                  ? ld_val_i[i] : status_i[i];
      end else begin : g_plain
         assign status_o[i] = (do_set && tgt == BI) ? 1'b1 :
                              (do_clr && tgt == BI) ? 1'b0 :
                              flag_op               ? status_i[i] :
                              ld_i                  ? ld_val_i[i] : status_i[i];
      end
   end
endmodule

// File: rtl/io_bit_seq.sv
module io_bit_seq #(
   parameter int DATA_W    = 8,
   parameter int IDX_W     = $clog2(DATA_W),
   parameter int IO_CYCLES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              go_i,
   input  logic              set_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [DATA_W-1:0] din_i,
   output logic              busy_o,
   output logic              fin_o,
   output logic [DATA_W-1:0] result_o
);
   localparam int CNT_W = $clog2(IO_CYCLES + 1);

   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] held_data;
   logic [IDX_W-1:0]  held_idx;
   logic              held_set;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt       <= '0;
         held_data <= '0;
         held_idx  <= '0;
         held_set  <= 1'b0;
      end else if (cnt != '0) begin
         cnt <= cnt - CNT_W'(1);
      end else if (go_i) begin
         cnt       <= CNT_W'(IO_CYCLES - 1);
         held_data <= din_i;
         held_idx  <= idx_i;
         held_set  <= set_i;
      end
   end

   assign busy_o = (cnt != '0);
   assign fin_o  = (cnt == CNT_W'(1));

   bit_patch #(.W(DATA_W), .IDX_W(IDX_W)) u_patch (
      .data_i (held_data),
      .idx_i  (held_idx),
      .val_i  (held_set),
      .data_o (result_o)
   );
endmodule

// File: rtl/flag_xfer_unit.sv
module flag_xfer_unit
   import flag_xfer_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int IDX_W     = $clog2(DATA_W),
   parameter int IO_CYCLES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [4:0]        op,
   input  logic [IDX_W-1:0]  bit_idx,
   input  logic [DATA_W-1:0] din,
   input  logic              flag_ld,
   input  logic [7:0]        flag_ld_val,
   output logic [7:0]        status,
   output logic [DATA_W-1:0] dout,
   output logic              dout_we,
   output logic              busy
);
   if (DATA_W < 8) begin : g_bad_width
      $error("flag_xfer_unit: DATA_W must be at least 8");
   end
   if (IO_CYCLES < 2) begin : g_bad_lat
      $error("flag_xfer_unit: IO_CYCLES must be at least 2");
   end

   logic              accept;
   logic [7:0]        status_nxt;
   logic              io_go, io_fin;
   logic [DATA_W-1:0] io_result, tload_result;

   assign accept = start && !busy;
   assign io_go  = accept && ((op == OP_IOSET) || (op == OP_IOCLR));

   flag_next #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_next (
      .accept_i (accept),
      .op_i     (op),
      .idx_i    (bit_idx),
      .din_i    (din),
      .ld_i     (flag_ld),
      .ld_val_i (flag_ld_val),
      .status_i (status),
      .status_o (status_nxt)
   );

   io_bit_seq #(.DATA_W(DATA_W), .IDX_W(IDX_W), .IO_CYCLES(IO_CYCLES)) u_io (
      .clk      (clk),
      .rst      (rst),
      .go_i     (io_go),
      .set_i    (op == OP_IOSET),
      .idx_i    (bit_idx),
      .din_i    (din),
      .busy_o   (busy),
      .fin_o    (io_fin),
      .result_o (io_result)
   );

   bit_patch #(.W(DATA_W), .IDX_W(IDX_W)) u_tload (
      .data_i (din),
      .idx_i  (bit_idx),
      .val_i  (status[T_IDX]),
      .data_o (tload_result)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         status  <= '0;
         dout    <= '0;
         dout_we <= 1'b0;
      end else begin
         status <= status_nxt;
         if (io_fin) begin
            dout    <= io_result;
            dout_we <= 1'b1;
         end else if (accept && op == OP_TLOAD) begin
            dout    <= tload_result;
            dout_we <= 1'b1;
         end else begin
            dout_we <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/flag_xfer_chk.sv
module flag_xfer_chk #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = $clog2(DATA_W)
) (
   input logic              clk,
   input logic              rst,
   input logic              start,
   input logic [4:0]        op,
   input logic [IDX_W-1:0]  bit_idx,
   input logic [DATA_W-1:0] din,
   input logic              flag_ld,
   input logic [7:0]        status,
   input logic [DATA_W-1:0] dout,
   input logic              dout_we,
   input logic              busy
);
   logic acc;
   assign acc = start && !busy;

   // R3
   p_flag_set_r3: assert property (@(posedge clk) disable iff (rst)
      acc && op == 5'd1 |=> status[$past(bit_idx[2:0])] == 1'b1);
   // R4
   p_flag_clr_r4: assert property (@(posedge clk) disable iff (rst)
      acc && op == 5'd2 |=> status[$past(bit_idx[2:0])] == 1'b0);
   // R6
   p_tstore_r6: assert property (@(posedge clk) disable iff (rst)
      acc && op == 5'd3 |=> status[6] == $past(din[bit_idx])
                            && (status & 8'hBF) == ($past(status) & 8'hBF));
   // R7
   p_tload_r7: assert property (@(posedge clk) disable iff (rst)
      acc && op == 5'd4 |=> dout_we && dout[$past(bit_idx)] == $past(status[6]));
   // R8
   p_io_busy_r8: assert property (@(posedge clk) disable iff (rst)
      acc && (op == 5'd5 || op == 5'd6) |=> busy);
   p_io_done_r8: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> dout_we);
   // R9
   p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
      busy && !flag_ld |=> $stable(status));
   // R11
   p_fast_ops_r11: assert property (@(posedge clk) disable iff (rst)
      acc && (op[4] || op == 5'd1 || op == 5'd2 || op == 5'd3 || op == 5'd4) |=> !busy);
endmodule

bind flag_xfer_unit flag_xfer_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .start   (start),
   .op      (op),
   .bit_idx (bit_idx),
   .din     (din),
   .flag_ld (flag_ld),
   .status  (status),
   .dout    (dout),
   .dout_we (dout_we),
   .busy    (busy)
);

// File: tb/tb_flag_xfer_unit.sv
module tb_flag_xfer_unit;
   logic       clk = 0;
   logic       rst = 1;
   logic       start = 0;
   logic [4:0] op = 0;
   logic [2:0] bit_idx = 0;
   logic [7:0] din = 0;
   logic       flag_ld = 0;
   logic [7:0] flag_ld_val = 0;
   logic [7:0] status, dout;
   logic       dout_we, busy;

   int checks = 0;
   int errors = 0;
   string tag = "R1";
   bit done = 0;

   // reference model state
   logic [7:0] m_status = 0, m_dout = 0;
   logic       m_we = 0;
   int         m_cnt = 0;
   logic [7:0] m_iod = 0;
   int         m_ioi = 0;
   logic       m_ios = 0;

   always #5 clk = ~clk;

   flag_xfer_unit dut (
      .clk(clk), .rst(rst), .start(start), .op(op), .bit_idx(bit_idx), .din(din),
      .flag_ld(flag_ld), .flag_ld_val(flag_ld_val), .status(status), .dout(dout),
      .dout_we(dout_we), .busy(busy)
   );

   always @(posedge clk) begin
      if (rst) begin
         m_status = 0; m_dout = 0; m_we = 0; m_cnt = 0;
      end else begin
         bit acc;
         bit flag_touch;
         int k;
         logic [7:0] old_st;
         old_st = m_status;
         acc = start && (m_cnt == 0);
         flag_touch = 0;
         m_we = 0;
         if (m_cnt > 0) begin
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) begin
               m_dout = m_iod;
               m_dout[m_ioi] = m_ios;
               m_we = 1;
            end
         end
         if (acc) begin
            if (op >= 16) begin
               k = int'(op[3:1]);
               m_status[k] = op[0];
               flag_touch = 1;
            end else if (op == 1) begin
               m_status[bit_idx] = 1'b1; flag_touch = 1;
            end else if (op == 2) begin
               m_status[bit_idx] = 1'b0; flag_touch = 1;
            end else if (op == 3) begin
               m_status[6] = din[bit_idx]; flag_touch = 1;
            end else if (op == 4) begin
               m_dout = din;
               m_dout[bit_idx] = old_st[6];
               m_we = 1;
            end else if (op == 5 || op == 6) begin
               m_cnt = 1; m_iod = din; m_ioi = int'(bit_idx); m_ios = (op == 5);
            end
         end
         if (!flag_touch && flag_ld) m_status = flag_ld_val;
      end
   end

   task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      chk("status", status, m_status);
      chk("dout", dout, m_dout);
      chk("dout_we", {7'd0, dout_we}, {7'd0, m_we});
      chk("busy", {7'd0, busy}, {7'd0, (m_cnt != 0)});
   endtask

   // drive at negedge after comparing the previous cycle's result
   task automatic cyc(logic s, logic [4:0] o, logic [2:0] i, logic [7:0] d,
                      logic l, logic [7:0] lv);
      @(negedge clk);
      compare();
      start = s; op = o; bit_idx = i; din = d; flag_ld = l; flag_ld_val = lv;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      tag = "R1";
      compare();
      rst = 0;
      for (int i = 0; i < 8; i++) begin
         tag = "R3"; cyc(1, 5'd1, 3'(i), 8'h00, 0, 8'h00);
      end
      for (int i = 0; i < 8; i++) begin
         tag = "R4"; cyc(1, 5'd2, 3'(i), 8'h00, 0, 8'h00);
      end
      for (int i = 16; i < 32; i++) begin
         tag = "R5"; cyc(1, 5'(i), 3'd0, 8'h00, 0, 8'h00);
      end
      tag = "R2";  cyc(1, 5'd9, 3'd2, 8'hFF, 0, 8'h00);
      tag = "R2";  cyc(1, 5'd0, 3'd1, 8'hFF, 0, 8'h00);
      for (int i = 0; i < 8; i++) begin
         tag = "R6"; cyc(1, 5'd3, 3'(i), 8'hA5, 0, 8'h00);
         tag = "R7"; cyc(1, 5'd4, 3'((i + 3) % 8), 8'h5A, 0, 8'h00);
      end
      tag = "R8";  cyc(1, 5'd5, 3'd4, 8'h01, 0, 8'h00);
      tag = "R9";  cyc(1, 5'd1, 3'd7, 8'h00, 0, 8'h00);
      tag = "R8";  cyc(0, 5'd0, 3'd0, 8'h00, 0, 8'h00);
      tag = "R8";  cyc(1, 5'd6, 3'd0, 8'hFF, 0, 8'h00);
      tag = "R9";  cyc(1, 5'd6, 3'd7, 8'hFF, 0, 8'h00);
      tag = "R8";  cyc(0, 5'd0, 3'd0, 8'h00, 0, 8'h00);
      tag = "R10"; cyc(0, 5'd0, 3'd0, 8'h00, 1, 8'h3C);
      tag = "R10"; cyc(1, 5'd1, 3'd0, 8'h00, 1, 8'hF0);
      tag = "R10"; cyc(1, 5'd4, 3'd0, 8'h00, 1, 8'h81);
      tag = "R10"; cyc(0, 5'd0, 3'd0, 8'h00, 0, 8'h00);
      for (int n = 0; n < 2000; n++) begin
         logic [4:0] o;
         int r;
         r = int'($urandom_range(0, 9));
         o = (r < 7) ? 5'(r) : 5'($urandom_range(16, 31));
         tag = "R11";
         cyc(1'($urandom_range(0, 1)), o, 3'($urandom_range(0, 7)), 8'($urandom),
             ($urandom_range(0, 3) == 0), 8'($urandom));
      end
      tag = "R11"; cyc(0, 5'd0, 3'd0, 8'h00, 0, 8'h00);
      @(negedge clk);
      compare();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule